// File: doc/BRIEF.md
# Buffered SPI Port with Single-Direction DMA Request

This block is one serial peripheral interface port that works as either bus master or bus slave. Each direction has a host-visible one-word buffer and, behind it, a shift register that the host cannot reach. A word that the host writes into the transmit buffer drops into the transmit shifter without further action. A word that finishes shifting in is copied into the receive buffer, and the host pops it with a read strobe. Data moves most significant bit first. Clock polarity and phase follow the four usual SPI modes.

As master, the port divides the system clock by 2 × (N+1) to make the serial clock. It drives MOSI, samples MISO, and pulls low every select output whose mask bit is set. As slave, it oversamples the incoming clock, data and select through synchronizers. It shifts only while the select input is low and drops any word left unfinished when select rises. One DMA request line serves either the transmit buffer or the receive buffer, chosen by a control bit. While it serves transmit, incoming words are thrown away.

The host interface is a write strobe with a 2-bit address and a read strobe. Address 0 is control: bit 0 enable, bit 1 master, bit 2 clock polarity, bit 3 clock phase, bit 4 DMA enable, bit 5 DMA direction (1 = receive). Address 1 is the transmit buffer. Address 2 is the divider N. Address 3 is the select mask.

Top module: `spi_dma_port`

## Requirements
- R1: After reset, tx_empty is 1, rx_full, rx_ovf and dma_req are 0, every ss_n_o bit is 1 and sclk_o is 0.
- R2: A write to address 1 clears tx_empty on the next cycle. The word moves into the hidden transmit shifter on its own: at the start of a master transfer, or when a slave is selected or finishes a word. tx_empty then returns to 1. A word written during a transfer is sent next with no further host action.
- R3: A completed word appears on rx_data with rx_full at 1, and a read strobe clears rx_full. Data shifts most significant bit first, so as master mosi_o shows bit 7 of the word one cycle after the transfer starts.
- R4: As master (control bits 0 and 1 set), a word lasts 2 × WORD_W × (N+1) clock cycles. rx_full rises 16(N+1)+2 falling edges after the falling edge that follows the transmit write. The idle sclk_o level equals the polarity bit. MISO is sampled on the leading edge when the phase bit is 0 and on the trailing edge when it is 1.
- R5: ss_n_o[i] is 0 exactly when the port is enabled, in master mode, and bit i of the address-3 mask is 1. Otherwise it is 1.
- R6: A word that arrives while rx_full is 1 sets rx_ovf and leaves the stored word unchanged. A read strobe clears both rx_full and rx_ovf.
- R7: With DMA enabled for transmit (bit 4 = 1, bit 5 = 0), dma_req equals tx_empty, and received words are discarded without setting rx_full.
- R8: With DMA enabled for receive (bits 4 and 5 = 1), dma_req equals rx_full and falls after the read strobe.
- R9: As slave (bit 0 set, bit 1 clear), the port samples mosi_i and drives miso_o in the configured mode, most significant bit first, and shifts only while ss_n_i is low.
- R10: A slave word cut short by ss_n_i rising is dropped and never reaches the receive buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | HOST_W | Host write data |
| rd_en | input | 1 | Pops the receive buffer |
| rx_data | output | WORD_W | Receive buffer contents |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_ovf | output | 1 | A word arrived while the receive buffer was full |
| dma_req | output | 1 | DMA request for the selected direction |
| sclk_o | output | 1 | Serial clock driven as master |
| mosi_o | output | 1 | Serial data out as master |
| miso_i | input | 1 | Serial data in as master |
| ss_n_o | output | NUM_SEL | Slave selects driven as master, active low |
| sclk_i | input | 1 | Serial clock received as slave |
| mosi_i | input | 1 | Serial data in as slave |
| miso_o | output | 1 | Serial data out as slave |
| ss_n_i | input | 1 | Device select as slave, active low |

## Verification
The assertions take the control register as changing only while no transfer is running. They also take the slave-side serial clock as changing no faster than once per several system clocks. A faster clock would let the synchronizer miss an edge, and the edge-derived checks would then mean nothing. The bench drives the slave pins with half periods of eight system clocks and changes select only with the clock at its idle level. It rewrites the control register only between words, so every stimulus stays inside those assumptions.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

   typedef struct packed {
      logic dma_rx;
      logic dma_en;
      logic cpha;
      logic cpol;
      logic master;
      logic en;
   } spi_ctrl_t;

   localparam int CTRL_W = $bits(spi_ctrl_t);

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_TX   = 2'd1;
   localparam logic [1:0] ADDR_DIV  = 2'd2;
   localparam logic [1:0] ADDR_SEL  = 2'd3;

endpackage

// File: rtl/spi_dma_regs.sv
module spi_dma_regs
   import spi_dma_pkg::*;
#(
   parameter int WORD_W  = 8,
   parameter int HOST_W  = 16,
   parameter int DIV_W   = 8,
   parameter int NUM_SEL = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [HOST_W-1:0]  wr_data,
   input  logic               rd_en,
   input  logic               tx_take,
   input  logic               rx_done,
   input  logic [WORD_W-1:0]  rx_word,
   output spi_ctrl_t          ctrl,
   output logic [DIV_W-1:0]   div,
   output logic [NUM_SEL-1:0] sel_mask,
   output logic [WORD_W-1:0]  tx_buf,
   output logic               tx_empty,
   output logic [WORD_W-1:0]  rx_buf,
   output logic               rx_full,
   output logic               rx_ovf,
   output logic               dma_req
);

   logic unused_wr_hi;
   assign unused_wr_hi = ^wr_data;

   logic rx_keep;
   logic rx_store;
   assign rx_keep  = !(ctrl.dma_en && !ctrl.dma_rx);
   assign rx_store = rx_done && rx_keep && (!rx_full || rd_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         div      <= '0;
         sel_mask <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: ctrl     <= spi_ctrl_t'(wr_data[CTRL_W-1:0]);
            ADDR_DIV:  div      <= wr_data[DIV_W-1:0];
            ADDR_SEL:  sel_mask <= wr_data[NUM_SEL-1:0];
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf   <= '0;
         tx_empty <= 1'b1;
      end else if (wr_en && wr_addr == ADDR_TX) begin
         tx_buf   <= wr_data[WORD_W-1:0];
         tx_empty <= 1'b0;
      end else if (tx_take) begin
         tx_empty <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf  <= '0;
         rx_full <= 1'b0;
         rx_ovf  <= 1'b0;
      end else begin
         if (rx_store) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
         end else if (rd_en) begin
            rx_full <= 1'b0;
         end
         if (rd_en)
            rx_ovf <= 1'b0;
         else if (rx_done && rx_keep && rx_full)
            rx_ovf <= 1'b1;
      end
   end

   assign dma_req = ctrl.dma_en && (ctrl.dma_rx ? rx_full : tx_empty);

endmodule

// File: rtl/spi_dma_master_eng.sv
module spi_dma_master_eng #(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [DIV_W-1:0]  div,
   input  logic              tx_avail,
   input  logic [WORD_W-1:0] tx_buf,
   input  logic              miso,
   output logic              take,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [WORD_W-1:0] word
);

   localparam int HC_W = $clog2(2 * WORD_W);
   localparam logic [HC_W-1:0] HC_LAST = HC_W'(2 * WORD_W - 1);

   logic [DIV_W-1:0]  div_cnt;
   logic [HC_W-1:0]   hc;
   logic [WORD_W-1:0] txsh;
   logic [WORD_W-1:0] rxsh;
   logic              busy_q;
   logic              sclk_q;
   logic              tick;
   logic              smp_edge;

   assign tick     = busy_q && (div_cnt == div);
   assign smp_edge = (hc[0] == cpha);
   assign take     = active && !busy_q && tx_avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         hc      <= '0;
         txsh    <= '0;
         rxsh    <= '0;
         busy_q  <= 1'b0;
         sclk_q  <= 1'b0;
         done    <= 1'b0;
         word    <= '0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            busy_q <= 1'b0;
            sclk_q <= cpol;
         end else if (!busy_q) begin
            sclk_q <= cpol;
            if (tx_avail) begin
               busy_q  <= 1'b1;
               txsh    <= tx_buf;
               div_cnt <= '0;
               hc      <= '0;
            end
         end else if (tick) begin
            div_cnt <= '0;
            sclk_q  <= ~sclk_q;
            hc      <= hc + 1'b1;
            if (smp_edge)
               rxsh <= {rxsh[WORD_W-2:0], miso};
            else if (!(cpha && hc == '0))
               txsh <= {txsh[WORD_W-2:0], 1'b0};
            if (hc == HC_LAST) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
               word   <= cpha ? {rxsh[WORD_W-2:0], miso} : rxsh;
            end
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign sclk = sclk_q;
   assign mosi = txsh[WORD_W-1];

endmodule

// File: rtl/spi_dma_slave_eng.sv
module spi_dma_slave_eng #(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              tx_avail,
   input  logic [WORD_W-1:0] tx_buf,
   input  logic              sclk_in,
   input  logic              mosi_in,
   input  logic              ss_n_in,
   output logic              take,
   output logic              miso,
   output logic              done,
   output logic [WORD_W-1:0] word
);

   localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

   logic [SYNC_STAGES-1:0] sclk_sync;
   logic [SYNC_STAGES-1:0] mosi_sync;
   logic [SYNC_STAGES-1:0] ss_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_sync <= '0;
         mosi_sync <= '0;
         ss_sync   <= '1;
      end else begin
         sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_in};
         mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_in};
         ss_sync   <= {ss_sync[SYNC_STAGES-2:0], ss_n_in};
      end
   end

   logic sclk_s, mosi_s, ss_s;
   assign sclk_s = sclk_sync[SYNC_STAGES-1];
   assign mosi_s = mosi_sync[SYNC_STAGES-1];
   assign ss_s   = ss_sync[SYNC_STAGES-1];

   logic              sclk_prev;
   logic              sel_q;
   logic              fresh;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] txsh;
   logic [WORD_W-1:0] rxsh;
   logic              unused_rx_top;
   assign unused_rx_top = rxsh[WORD_W-1];

   logic moved, lead, trail, smp, shf, selected, start, last;
   assign moved    = sclk_s != sclk_prev;
   assign lead     = moved && (sclk_s != cpol);
   assign trail    = moved && (sclk_s == cpol);
   assign smp      = cpha ? trail : lead;
   assign shf      = cpha ? lead : trail;
   assign selected = active && !ss_s;
   assign start    = selected && !sel_q;
   assign last     = selected && sel_q && smp && (cnt == CNT_LAST);
   assign take     = (start || last) && tx_avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         sel_q     <= 1'b0;
         fresh     <= 1'b0;
         cnt       <= '0;
         txsh      <= '0;
         rxsh      <= '0;
         done      <= 1'b0;
         word      <= '0;
      end else begin
         sclk_prev <= sclk_s;
         sel_q     <= selected;
         done      <= 1'b0;
         if (!selected) begin
            cnt   <= '0;
            fresh <= 1'b0;
         end else if (start) begin
            txsh  <= tx_avail ? tx_buf : '0;
            fresh <= cpha;
            cnt   <= '0;
         end else if (smp) begin
            rxsh <= {rxsh[WORD_W-2:0], mosi_s};
            if (cnt == CNT_LAST) begin
               done  <= 1'b1;
               word  <= {rxsh[WORD_W-2:0], mosi_s};
               cnt   <= '0;
               txsh  <= tx_avail ? tx_buf : '0;
               fresh <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (shf) begin
            if (fresh)
               fresh <= 1'b0;
            else
               txsh <= {txsh[WORD_W-2:0], 1'b0};
         end
      end
   end

   assign miso = txsh[WORD_W-1];

endmodule

// File: rtl/spi_dma_port.sv
module spi_dma_port
   import spi_dma_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int HOST_W      = 16,
   parameter int DIV_W       = 8,
   parameter int NUM_SEL     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [HOST_W-1:0]  wr_data,
   input  logic               rd_en,
   output logic [WORD_W-1:0]  rx_data,
   output logic               tx_empty,
   output logic               rx_full,
   output logic               rx_ovf,
   output logic               dma_req,
   output logic               sclk_o,
   output logic               mosi_o,
   input  logic               miso_i,
   output logic [NUM_SEL-1:0] ss_n_o,
   input  logic               sclk_i,
   input  logic               mosi_i,
   output logic               miso_o,
   input  logic               ss_n_i
);

   if (WORD_W < 2) begin : g_chk_word
      $error("WORD_W must be at least 2");
   end
   if (HOST_W < WORD_W || HOST_W < DIV_W || HOST_W < NUM_SEL || HOST_W < CTRL_W) begin : g_chk_host
      $error("HOST_W must cover every register field");
   end
   if (NUM_SEL < 1 || DIV_W < 1) begin : g_chk_sel
      $error("NUM_SEL and DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   spi_ctrl_t          ctrl_q;
   logic [DIV_W-1:0]   div_q;
   logic [NUM_SEL-1:0] sel_mask;
   logic [WORD_W-1:0]  tx_buf;
   logic               m_take, s_take, m_done, s_done, m_busy;
   logic [WORD_W-1:0]  m_word, s_word;
   logic               rx_done;
   logic [WORD_W-1:0]  rx_word;
   logic               m_active, s_active;

   assign m_active = ctrl_q.en && ctrl_q.master;
   assign s_active = ctrl_q.en && !ctrl_q.master;
   assign rx_done  = m_done || s_done;
   assign rx_word  = m_done ? m_word : s_word;

   spi_dma_regs #(
      .WORD_W(WORD_W), .HOST_W(HOST_W), .DIV_W(DIV_W), .NUM_SEL(NUM_SEL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
      .tx_take(m_take || s_take), .rx_done(rx_done), .rx_word(rx_word),
      .ctrl(ctrl_q), .div(div_q), .sel_mask(sel_mask),
      .tx_buf(tx_buf), .tx_empty(tx_empty),
      .rx_buf(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf), .dma_req(dma_req)
   );

   spi_dma_master_eng #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_master (
      .clk(clk), .rst_n(rst_n), .active(m_active),
      .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .div(div_q),
      .tx_avail(!tx_empty), .tx_buf(tx_buf), .miso(miso_i),
      .take(m_take), .busy(m_busy), .sclk(sclk_o), .mosi(mosi_o),
      .done(m_done), .word(m_word)
   );

   spi_dma_slave_eng #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
      .clk(clk), .rst_n(rst_n), .active(s_active),
      .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
      .tx_avail(!tx_empty), .tx_buf(tx_buf),
      .sclk_in(sclk_i), .mosi_in(mosi_i), .ss_n_in(ss_n_i),
      .take(s_take), .miso(miso_o), .done(s_done), .word(s_word)
   );

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      assign ss_n_o[i] = !(m_active && sel_mask[i]);
   end

endmodule

// File: rtl/spi_dma_port_chk.sv
module spi_dma_port_chk
   import spi_dma_pkg::*;
#(
   parameter int NUM_SEL = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_addr,
   input logic               rd_en,
   input logic               tx_empty,
   input logic               rx_full,
   input logic               rx_ovf,
   input logic               dma_req,
   input logic               sclk_o,
   input logic [NUM_SEL-1:0] ss_n_o,
   input spi_ctrl_t          ctrl,
   input logic               m_busy,
   input logic               rx_done
);

   logic ctrl_wr;
   assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

   // R2
   p_tx_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_TX) |=> !tx_empty);

   // R4
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_busy && $past(!m_busy) && $stable(ctrl.cpol) && !ctrl_wr) |-> (sclk_o == ctrl.cpol));

   // R5
   p_sel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl.en && ctrl.master) |-> (&ss_n_o));

   // R6
   p_ovf_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovf) |-> $past(rx_full));

   // R7
   p_tx_dma_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.dma_en && !ctrl.dma_rx && !rx_full) |=> !rx_full);

   // R8
   p_rx_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.dma_en && ctrl.dma_rx && rd_en && !rx_done && !ctrl_wr) |=> !dma_req);

endmodule

bind spi_dma_port spi_dma_port_chk #(.NUM_SEL(NUM_SEL)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
   .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf), .dma_req(dma_req),
   .sclk_o(sclk_o), .ss_n_o(ss_n_o), .ctrl(ctrl_q), .m_busy(m_busy),
   .rx_done(rx_done)
);

// File: tb/tb_spi_dma_port.sv
module tb_spi_dma_port;

   localparam int CLK_PERIOD = 10;
   localparam int W    = 8;
   localparam int HW   = 16;
   localparam int NSEL = 4;
   localparam int H    = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_addr = '0;
   logic [HW-1:0]   wr_data = '0;
   logic            rd_en = 1'b0;
   logic            sclk_i = 1'b0;
   logic            mosi_i = 1'b0;
   logic            ss_n_i = 1'b1;
   logic            loop_en = 1'b1;
   logic [W-1:0]    rx_data;
   logic            tx_empty, rx_full, rx_ovf, dma_req;
   logic            sclk_o, mosi_o, miso_o;
   logic [NSEL-1:0] ss_n_o;
   logic            miso_i;

   assign miso_i = loop_en ? mosi_o : 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_dma_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rx_data(rx_data),
      .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf),
      .dma_req(dma_req), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
      .ss_n_o(ss_n_o), .sclk_i(sclk_i), .mosi_i(mosi_i), .miso_o(miso_o),
      .ss_n_i(ss_n_i)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   bit          mon_on = 1'b1;
   logic [W-1:0] exp_q[$];

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic host_wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = HW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops the receive buffer and compares against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rd_en) rd_en = 1'b0;
         else if (mon_on && rx_full) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R3 unexpected word", rx_data, 0);
            else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(rx_data == e, "R3 received word", rx_data, e);
            end
            rd_en = 1'b1;
         end
      end
   end

   task automatic wait_drain();
      for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
      idle(3);
      chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
   endtask

   task automatic master_xfer(input logic [W-1:0] d, input int div);
      int cyc;
      host_wr(1, d);
      @(negedge clk);
      cyc = 1;
      chk(mosi_o == d[W-1], "R3 MSB first on mosi_o", mosi_o, d[W-1]);
      while (!rx_full && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc == 16*(div+1)+2, "R4 word duration", cyc, 16*(div+1)+2);
   endtask

   task automatic master_mode(input bit cpol, input bit cpha, input int div,
                              input logic [NSEL-1:0] mask, input logic [W-1:0] d);
      host_wr(2, div);
      host_wr(3, mask);
      host_wr(0, 32'h3 | (int'(cpol) << 2) | (int'(cpha) << 3));
      idle(2);
      chk(ss_n_o == ~mask, "R5 select outputs", ss_n_o, ~mask);
      chk(sclk_o == cpol, "R4 idle clock level", sclk_o, cpol);
      exp_q.push_back(d);
      master_xfer(d, div);
      idle(2);
      chk(sclk_o == cpol, "R4 idle clock after word", sclk_o, cpol);
      chk(tx_empty == 1'b1, "R2 buffer drained into shifter", tx_empty, 1);
      wait_drain();
   endtask

   task automatic slave_bits(input logic [W-1:0] d, input int n, input bit cpol,
                             input bit cpha, output logic [W-1:0] got);
      got = '0;
      ss_n_i = 1'b0;
      idle(8);
      for (int i = 0; i < n; i++) begin
         if (!cpha) begin
            mosi_i = d[W-1-i];
            idle(H);
            got = {got[W-2:0], miso_o};
            sclk_i = ~cpol;
            idle(H);
            sclk_i = cpol;
         end else begin
            sclk_i = ~cpol;
            mosi_i = d[W-1-i];
            idle(H);
            got = {got[W-2:0], miso_o};
            sclk_i = cpol;
            idle(H);
         end
      end
      idle(H);
      ss_n_i = 1'b1;
      idle(8);
   endtask

   task automatic slave_mode(input bit cpol, input bit cpha,
                             input logic [W-1:0] txw, input logic [W-1:0] rxw);
      logic [W-1:0] got;
      sclk_i = cpol;
      host_wr(0, 32'h1 | (int'(cpol) << 2) | (int'(cpha) << 3));
      idle(4);
      chk(ss_n_o == '1, "R5 selects high as slave", ss_n_o, 4'hF);
      host_wr(1, txw);
      exp_q.push_back(rxw);
      slave_bits(rxw, W, cpol, cpha, got);
      chk(got == txw, "R9 slave miso word", got, txw);
      chk(tx_empty == 1'b1, "R2 slave took buffer", tx_empty, 1);
      wait_drain();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      loop_en = 1'b1;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
      chk(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
      chk(rx_ovf == 1'b0, "R1 rx_ovf", rx_ovf, 0);
      chk(dma_req == 1'b0, "R1 dma_req", dma_req, 0);
      chk(ss_n_o == '1, "R1 ss_n_o", ss_n_o, 4'hF);
      chk(sclk_o == 1'b0, "R1 sclk_o", sclk_o, 0);

      // master loopback, all four modes
      master_mode(1'b0, 1'b0, 1, 4'b0010, 8'hA5);
      master_mode(1'b0, 1'b1, 0, 4'b1001, 8'h3C);
      master_mode(1'b1, 1'b0, 2, 4'b0100, 8'h81);
      master_mode(1'b1, 1'b1, 1, 4'b1111, 8'h5E);

      // R2 back-to-back words
      host_wr(0, 32'h3);
      host_wr(2, 0);
      exp_q.push_back(8'hC7);
      exp_q.push_back(8'h1B);
      host_wr(1, 8'hC7);
      host_wr(1, 8'h1B);
      chk(tx_empty == 1'b0, "R2 second word queued", tx_empty, 0);
      wait_drain();

      // R6 overflow
      mon_on = 1'b0;
      master_xfer(8'h11, 0);
      host_wr(1, 8'h22);
      idle(30);
      chk(rx_ovf == 1'b1, "R6 overflow set", rx_ovf, 1);
      chk(rx_full == 1'b1, "R6 still full", rx_full, 1);
      chk(rx_data == 8'h11, "R6 old word kept", rx_data, 8'h11);
      exp_q.push_back(8'h11);
      mon_on = 1'b1;
      idle(4);
      chk(rx_ovf == 1'b0, "R6 overflow cleared by read", rx_ovf, 0);
      chk(rx_full == 1'b0, "R6 full cleared by read", rx_full, 0);
      wait_drain();

      // R7 transmit DMA
      host_wr(0, 32'h13);
      idle(1);
      chk(dma_req == 1'b1, "R7 request while tx empty", dma_req, 1);
      host_wr(1, 8'h77);
      chk(dma_req == 1'b0, "R7 request drops on fill", dma_req, 0);
      idle(40);
      chk(rx_full == 1'b0, "R7 received word discarded", rx_full, 0);
      chk(dma_req == 1'b1, "R7 request back after take", dma_req, 1);

      // R8 receive DMA
      host_wr(0, 32'h33);
      mon_on = 1'b0;
      idle(1);
      chk(dma_req == 1'b0, "R8 no request when empty", dma_req, 0);
      master_xfer(8'h9C, 0);
      chk(dma_req == 1'b1, "R8 request when full", dma_req, 1);
      exp_q.push_back(8'h9C);
      mon_on = 1'b1;
      idle(4);
      chk(dma_req == 1'b0, "R8 request clears on read", dma_req, 0);
      wait_drain();

      // R9 slave modes 0 and 3
      loop_en = 1'b0;
      host_wr(0, 32'h0);
      idle(2);
      slave_mode(1'b0, 1'b0, 8'hC3, 8'h96);
      slave_mode(1'b1, 1'b1, 8'h5A, 8'h2D);

      // R10 partial word dropped
      begin
         logic [W-1:0] got;
         sclk_i = 1'b0;
         host_wr(0, 32'h1);
         idle(4);
         slave_bits(8'hFF, 3, 1'b0, 1'b0, got);
         idle(4);
         chk(rx_full == 1'b0, "R10 partial word dropped", rx_full, 0);
         exp_q.push_back(8'h69);
         slave_bits(8'h69, W, 1'b0, 1'b0, got);
         wait_drain();
         chk(rx_ovf == 1'b0, "R10 no overflow after partial", rx_ovf, 0);
      end

      finish_run();
   end

endmodule